// File: doc/BRIEF.md
# Multiplexed-Bus Peripheral Decoder

This block sits beside an 8-bit microcontroller whose external bus shares eight lines between the low address byte and the data byte. While the address strobe is high, it holds the low byte taken from those shared lines. It joins that byte with the high address byte, which arrives on a port of its own, to form a 16-bit address. From that address it derives an active-low select for an external SRAM that covers the upper half of the address space, and per-page selects for a set of 256-byte peripheral pages.

Inside the decoded I/O region, the block contains the output port registers, which are loaded by write strobes. It returns input port pins on the data bus during read strobes. It also produces the register-select, read/write and enable lines for a character LCD. The shared data lines are split into an input, an output and an output-enable, so that contention and the high-impedance state can be observed directly.

Top module: `chipset_top`

## Requirements
- R1: The low address byte follows `ad_in` while `ale` is high. It is held, unchanged by later `ad_in` activity, once `ale` is low. The value takes effect from the cycle `ale` is sampled at a clock edge, and it is visible without delay while `ale` is high.
- R2: `sram_cs_n` is low exactly when address bit 15 is 1 and the cycle is a valid access. A valid access has exactly one of `rd_n` or `wr_n` low, and `rst` low.
- R3: `ser_cs_n` is low exactly during a valid access with high byte 0x27.
- R4: `lcd_en` is high only during a valid access with high byte 0x20. `lcd_rs` equals low address bit 1 and `lcd_rw` equals low address bit 0, so 0x2000, 0x2001, 0x2002 and 0x2003 are instruction write, instruction read, data write and data read.
- R5: A valid write to page 0x21, 0x23 or 0x25 loads `ad_in` at the clock edge into byte 0, 1 or 2 of `out_pins`. The byte holds its value until the next write to that page.
- R6: A valid read of page 0x22, 0x24 or 0x26 sets `ad_oe` and drives byte 0, 1 or 2 of `in_pins` on `ad_out` in the same cycle.
- R7: `ad_oe` is low whenever no valid read of an input page is in progress. This includes reads of output pages, the LCD, the serial page and SRAM.
- R8: Addresses 0x2800 to 0x7FFF select nothing. Writes there leave `out_pins` unchanged, and reads there leave `ad_oe` low.
- R9: While `rst` is high, every select is inactive and `ad_oe` is low. After a reset edge, `out_pins` is zero.
- R10: A cycle with `rd_n` and `wr_n` both low asserts no select. It loads no port and does not drive the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ale | input | 1 | Address strobe; low address byte is present on `ad_in` while high |
| ad_in | input | 8 | Shared address/data lines as seen by the block |
| ad_out | output | 8 | Data the block places on the shared lines |
| ad_oe | output | 1 | Drive enable for `ad_out` |
| a_hi | input | 8 | High address byte |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| sram_cs_n | output | 1 | Active-low external SRAM select |
| ser_cs_n | output | 1 | Active-low serial page select |
| lcd_rs | output | 1 | LCD register select |
| lcd_rw | output | 1 | LCD read/write line |
| lcd_en | output | 1 | LCD enable |
| out_pins | output | 24 | Output port bytes, byte 0 for page 0x21 |
| in_pins | input | 24 | Input port bytes, byte 0 for page 0x22 |

## Verification
The bench builds the block with its default three output ports and three input ports. With these values every decoded page between 0x20 and 0x27 is in use, and the byte lanes at both edges of the packed pin vectors are exercised. A behavioural model that holds the latched byte and the port contents is compared with every output on every cycle. Directed accesses reach the page edges at 0x1FFF, 0x2000, 0x27FF, 0x2800, 0x7FFF and 0x8000, the overlapped-strobe case, and strobes issued during reset.

// File: rtl/chipset_pkg.sv
package chipset_pkg;

    localparam int DW          = 8;
    localparam int DEF_NUM_OUT = 3;
    localparam int DEF_NUM_IN  = 3;

    localparam logic [7:0] PG_LCD    = 8'h20;
    localparam logic [7:0] PG_SER    = 8'h27;
    localparam logic [7:0] PG_OUT0   = 8'h21;
    localparam logic [7:0] PG_IN0    = 8'h22;
    localparam int         PG_STRIDE = 2;

    typedef enum logic [1:0] {
        ACC_IDLE = 2'd0,
        ACC_RD   = 2'd1,
        ACC_WR   = 2'd2,
        ACC_BAD  = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic [15:0] addr;
        acc_kind_e   kind;
    } bus_acc_t;

    function automatic acc_kind_e classify(input logic rd_n, input logic wr_n,
                                           input logic rst);
        if (rst)
            return ACC_IDLE;
        case ({rd_n, wr_n})
            2'b01:   return ACC_RD;
            2'b10:   return ACC_WR;
            2'b00:   return ACC_BAD;
            default: return ACC_IDLE;
        endcase
    endfunction

    function automatic logic [7:0] out_page(input int idx);
        return PG_OUT0 + 8'(PG_STRIDE * idx);
    endfunction

    function automatic logic [7:0] in_page(input int idx);
        return PG_IN0 + 8'(PG_STRIDE * idx);
    endfunction

endpackage

// File: rtl/cs_addr_latch.sv
module cs_addr_latch #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ale,
    input  logic [AW-1:0] ad_in,
    output logic [AW-1:0] lo_addr
);
    logic [AW-1:0] held_q;

    always_ff @(posedge clk) begin
        if (rst)
            held_q <= '0;
        else if (ale)
            held_q <= ad_in;
    end

    // transparent while the strobe is high, held afterwards
    assign lo_addr = ale ? ad_in : held_q;
endmodule

// File: rtl/cs_page_decode.sv
module cs_page_decode
    import chipset_pkg::*;
#(
    parameter int NUM_OUT = DEF_NUM_OUT,
    parameter int NUM_IN  = DEF_NUM_IN
) (
    input  bus_acc_t            acc,
    output logic                sram_sel,
    output logic                ser_sel,
    output logic                lcd_sel,
    output logic [NUM_OUT-1:0]  out_wr,
    output logic [NUM_IN-1:0]   in_rd
);
    logic [7:0] hi;
    logic       live;

    assign hi       = acc.addr[15:8];
    assign live     = (acc.kind == ACC_RD) || (acc.kind == ACC_WR);
    assign sram_sel = live && acc.addr[15];
    assign ser_sel  = live && (hi == PG_SER);
    assign lcd_sel  = live && (hi == PG_LCD);

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
        assign out_wr[i] = (acc.kind == ACC_WR) && (hi == out_page(i));
    end

    for (genvar j = 0; j < NUM_IN; j++) begin : g_in
        assign in_rd[j] = (acc.kind == ACC_RD) && (hi == in_page(j));
    end
endmodule

// File: rtl/cs_out_bank.sv
module cs_out_bank #(
    parameter int NUM_OUT = 3,
    parameter int W       = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_OUT-1:0]   wr_sel,
    input  logic [W-1:0]         din,
    output logic [NUM_OUT*W-1:0] pins
);
    for (genvar i = 0; i < NUM_OUT; i++) begin : g_reg
        logic [W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (wr_sel[i])
                q <= din;
        end
        assign pins[i*W +: W] = q;
    end
endmodule

// File: rtl/cs_in_mux.sv
module cs_in_mux #(
    parameter int NUM_IN = 3,
    parameter int W      = 8
) (
    input  logic [NUM_IN-1:0]   rd_sel,
    input  logic [NUM_IN*W-1:0] pins,
    output logic [W-1:0]        dout,
    output logic                oe
);
    always_comb begin
        dout = '0;
        for (int i = 0; i < NUM_IN; i++) begin
            if (rd_sel[i])
                dout = dout | pins[i*W +: W];
        end
    end

    assign oe = |rd_sel;
endmodule

// File: rtl/chipset_top.sv
module chipset_top
    import chipset_pkg::*;
#(
    parameter int NUM_OUT = DEF_NUM_OUT,
    parameter int NUM_IN  = DEF_NUM_IN
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ale,
    input  logic [DW-1:0]         ad_in,
    output logic [DW-1:0]         ad_out,
    output logic                  ad_oe,
    input  logic [7:0]            a_hi,
    input  logic                  rd_n,
    input  logic                  wr_n,
    output logic                  sram_cs_n,
    output logic                  ser_cs_n,
    output logic                  lcd_rs,
    output logic                  lcd_rw,
    output logic                  lcd_en,
    output logic [NUM_OUT*DW-1:0] out_pins,
    input  logic [NUM_IN*DW-1:0]  in_pins
);
    logic [DW-1:0]      lo_addr;
    bus_acc_t           acc;
    logic               sram_sel, ser_sel, lcd_sel;
    logic [NUM_OUT-1:0] out_wr;
    logic [NUM_IN-1:0]  in_rd;

    cs_addr_latch #(.AW(DW)) u_latch (
        .clk     (clk),
        .rst     (rst),
        .ale     (ale),
        .ad_in   (ad_in),
        .lo_addr (lo_addr)
    );

    assign acc.addr = {a_hi, lo_addr};
    assign acc.kind = classify(rd_n, wr_n, rst);

    cs_page_decode #(.NUM_OUT(NUM_OUT), .NUM_IN(NUM_IN)) u_dec (
        .acc      (acc),
        .sram_sel (sram_sel),
        .ser_sel  (ser_sel),
        .lcd_sel  (lcd_sel),
        .out_wr   (out_wr),
        .in_rd    (in_rd)
    );

    cs_out_bank #(.NUM_OUT(NUM_OUT), .W(DW)) u_out (
        .clk    (clk),
        .rst    (rst),
        .wr_sel (out_wr),
        .din    (ad_in),
        .pins   (out_pins)
    );

    cs_in_mux #(.NUM_IN(NUM_IN), .W(DW)) u_in (
        .rd_sel (in_rd),
        .pins   (in_pins),
        .dout   (ad_out),
        .oe     (ad_oe)
    );

    assign sram_cs_n = ~sram_sel;
    assign ser_cs_n  = ~ser_sel;
    assign lcd_en    = lcd_sel;
    assign lcd_rs    = lo_addr[1];
    assign lcd_rw    = lo_addr[0];
endmodule

// File: rtl/chipset_checker.sv
module chipset_checker #(
    parameter int OW = 24
) (
    input logic          clk,
    input logic          rst,
    input logic          rd_n,
    input logic          wr_n,
    input logic [7:0]    a_hi,
    input logic          ad_oe,
    input logic          sram_cs_n,
    input logic          ser_cs_n,
    input logic          lcd_en,
    input logic [OW-1:0] out_pins
);
    // R6 / R7: the bus is driven only under a lone read strobe
    p_oe_only_on_read_r7: assert property (@(posedge clk) disable iff (rst)
        ad_oe |-> (!rd_n && wr_n));

    // R2: SRAM select implies the upper half of the map
    p_sram_upper_r2: assert property (@(posedge clk) disable iff (rst)
        !sram_cs_n |-> a_hi[7]);

    // R4: LCD enable needs exactly one strobe and the LCD page
    p_lcd_en_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        lcd_en |-> ((rd_n ^ wr_n) && a_hi == 8'h20));

    // R3: serial select only in its page
    p_ser_page_r3: assert property (@(posedge clk) disable iff (rst)
        !ser_cs_n |-> (a_hi == 8'h27));

    // R10: overlapped strobes select nothing
    p_overlap_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (!rd_n && !wr_n) |-> (sram_cs_n && ser_cs_n && !lcd_en && !ad_oe));

    // R5: port bytes hold when no write strobe was sampled
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        wr_n |=> $stable(out_pins));

    // R9: reset clears the ports and silences every select
    p_reset_clear_r9: assert property (@(posedge clk)
        rst |=> (out_pins == '0));
    p_reset_quiet_r9: assert property (@(posedge clk)
        rst |-> (sram_cs_n && ser_cs_n && !lcd_en && !ad_oe));
endmodule

bind chipset_top chipset_checker #(.OW(NUM_OUT * chipset_pkg::DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .a_hi      (a_hi),
    .ad_oe     (ad_oe),
    .sram_cs_n (sram_cs_n),
    .ser_cs_n  (ser_cs_n),
    .lcd_en    (lcd_en),
    .out_pins  (out_pins)
);

// File: tb/sim_chipset_top.sv
`timescale 1ns/1ps
module sim_chipset_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ale = 1'b0;
    logic [7:0]  ad_in = 8'h00;
    logic [7:0]  ad_out;
    logic        ad_oe;
    logic [7:0]  a_hi = 8'h00;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        sram_cs_n, ser_cs_n, lcd_rs, lcd_rw, lcd_en;
    logic [23:0] out_pins;
    logic [23:0] in_pins = 24'h9C5AC3;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit armed  = 1'b0;
    bit done   = 1'b0;

    // behavioural model state
    logic [7:0] m_lo = 8'h00;
    logic [7:0] m_port [3];

    always #4 clk = ~clk;

    chipset_top u0 (
        .clk(clk), .rst(rst), .ale(ale), .ad_in(ad_in), .ad_out(ad_out),
        .ad_oe(ad_oe), .a_hi(a_hi), .rd_n(rd_n), .wr_n(wr_n),
        .sram_cs_n(sram_cs_n), .ser_cs_n(ser_cs_n), .lcd_rs(lcd_rs),
        .lcd_rw(lcd_rw), .lcd_en(lcd_en), .out_pins(out_pins),
        .in_pins(in_pins)
    );

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    // model update at each edge, from the inputs present before it
    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_lo = 8'h00;
            for (int k = 0; k < 3; k++) m_port[k] = 8'h00;
        end else begin
            if (!wr_n && rd_n) begin
                case (a_hi)
                    8'h21: m_port[0] = ad_in;
                    8'h23: m_port[1] = ad_in;
                    8'h25: m_port[2] = ad_in;
                    default: ;
                endcase
            end
            if (ale) m_lo = ad_in;
        end
        armed = 1'b1;
        if (cyc > 20000) begin
            n_fail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    // full comparison away from the active edge
    always @(negedge clk) begin
        if (armed && !done) begin
            logic [7:0] lo;
            bit good, rd_ok;
            int idx;
            lo    = ale ? ad_in : m_lo;
            good  = !rst && (rd_n != wr_n);
            rd_ok = !rst && !rd_n && wr_n &&
                    (a_hi == 8'h22 || a_hi == 8'h24 || a_hi == 8'h26);
            check("R2 sram_cs_n", 32'(sram_cs_n), 32'(!(good && a_hi >= 8'h80)));
            check("R3 ser_cs_n",  32'(ser_cs_n),  32'(!(good && a_hi == 8'h27)));
            check("R4 lcd_en",    32'(lcd_en),    32'(good && a_hi == 8'h20));
            check("R1 R4 lcd_rs/rw", {30'd0, lcd_rs, lcd_rw}, {30'd0, lo[1], lo[0]});
            check("R5 out_pins", 32'(out_pins), {8'h00, m_port[2], m_port[1], m_port[0]});
            check("R7 ad_oe", 32'(ad_oe), 32'(rd_ok));
            if (rd_ok) begin
                idx = (int'(a_hi) - 'h22) / 2;
                check("R6 ad_out", 32'(ad_out), 32'(in_pins[idx*8 +: 8]));
            end
        end
    end

    // one complete access: address phase then strobe phase
    task automatic access(input logic [15:0] addr, input bit rd, input bit wr,
                          input logic [7:0] data);
        @(posedge clk); #1;
        ale = 1'b1; ad_in = addr[7:0]; a_hi = addr[15:8]; rd_n = 1'b1; wr_n = 1'b1;
        @(posedge clk); #1;
        ale = 1'b0; ad_in = data; rd_n = !rd; wr_n = !wr;
        @(posedge clk); #1;
        rd_n = 1'b1; wr_n = 1'b1; ad_in = 8'h00;
    endtask

    initial begin
        // R9: strobes during reset must be ignored
        @(posedge clk); #1;
        a_hi = 8'h80; rd_n = 1'b0;
        @(posedge clk); #1;
        a_hi = 8'h21; rd_n = 1'b1; wr_n = 1'b0; ad_in = 8'hFF;
        @(posedge clk); #1;
        wr_n = 1'b1;
        @(posedge clk); #1;
        check("R9 out_pins after reset", 32'(out_pins), 32'h0);
        check("R9 sram quiet in reset", 32'(sram_cs_n), 32'h1);
        rst = 1'b0;

        // R5: write each output page
        access(16'h2100, 0, 1, 8'hA5);
        access(16'h2342, 0, 1, 8'h3C);
        access(16'h25FF, 0, 1, 8'hF0);
        #2 check("R5 all ports", 32'(out_pins), 32'h00F03CA5);

        // R10: overlapped strobes on an output page
        access(16'h2300, 1, 1, 8'h11);
        #2 check("R10 no write on overlap", 32'(out_pins), 32'h00F03CA5);

        // R8: unmapped writes and reads
        access(16'h2800, 0, 1, 8'h77);
        access(16'h7FFF, 0, 1, 8'h66);
        access(16'h4021, 1, 0, 8'h00);
        #2 check("R8 unmapped leaves ports", 32'(out_pins), 32'h00F03CA5);

        // R6 / R7: input pages, then an output page read
        access(16'h2200, 1, 0, 8'h00);
        access(16'h2410, 1, 0, 8'h00);
        in_pins = 24'h0180FE;
        access(16'h26FF, 1, 0, 8'h00);
        access(16'h2200, 1, 0, 8'h00);
        access(16'h2500, 1, 0, 8'h00);

        // R2: SRAM window edges
        access(16'h8000, 1, 0, 8'h00);
        access(16'hFFFF, 0, 1, 8'h12);
        access(16'h7FFF, 1, 0, 8'h00);

        // R3: serial page edges and neighbours
        access(16'h2700, 1, 0, 8'h00);
        access(16'h27FF, 0, 1, 8'h34);
        access(16'h1FFF, 1, 0, 8'h00);

        // R4: the four LCD addresses
        access(16'h2000, 0, 1, 8'h38);
        access(16'h2001, 1, 0, 8'h00);
        access(16'h2002, 0, 1, 8'h41);
        access(16'h2003, 1, 0, 8'h00);

        // R1: the held byte ignores data on the shared lines
        @(posedge clk); #1;
        ale = 1'b1; ad_in = 8'h02; a_hi = 8'h20;
        @(posedge clk); #1;
        ale = 1'b0; ad_in = 8'hFD;
        #2 check("R1 held low byte", {30'd0, lcd_rs, lcd_rw}, 32'h2);
        @(posedge clk); #1;
        ale = 1'b1; ad_in = 8'h01;
        #2 check("R1 transparent low byte", {30'd0, lcd_rs, lcd_rw}, 32'h1);
        @(posedge clk); #1;
        ale = 1'b0;

        // R9: reset again clears the ports
        rst = 1'b1;
        @(posedge clk); #1;
        rst = 1'b0;
        #2 check("R9 re-reset", 32'(out_pins), 32'h0);

        repeat (3) @(posedge clk);
        finish_run();
    end
endmodule